// File: doc/BRIEF.md
# Double Bus Fault Halt Monitor

This block watches the execution phase of a processor and the bus-error events it sees, and decides when a bus error is a second, unrecoverable fault. Three protected windows are tracked. The first is the stretch after reset release before the first instruction is fetched. The second runs from the start of bus-error exception processing until the first handler instruction is fetched. The third covers the time while a return-from-exception is reloading a bus-error stack frame. A bus error inside any open window is a double fault.

The response depends on a monitor-enable input. With the monitor disabled, the block raises a halt output and keeps it high until the next external reset. With the monitor enabled, it issues a reset request pulse of a parameterised length and does not halt. A sticky three-bit status field records which windows were open when an accepted fault occurred.

Bus-error generation and the processor pipeline sit outside this block. The block only consumes one-cycle event strobes and a level for the stack-frame reload.

Top module: `dbf_halt_monitor`

## Requirements
- R1: While reset is asserted and in the first cycle after its release, halt and mon_rst_req are 0 and fault_src is 3'b000.
- R2: The post-reset window is open from reset release until the cycle in which first_fetch is high, inclusive. A bus_err in that window is a double fault and sets fault_src bit 0.
- R3: An exc_start strobe opens the exception window from the following cycle up to and including the next first_fetch cycle. A bus_err in that window is a double fault and sets fault_src bit 1. A bus_err in the same cycle as exc_start is not counted.
- R4: A bus_err in any cycle with rte_reload high is a double fault and sets fault_src bit 2. Once rte_reload is low, this window is closed.
- R5: A bus_err while no window is open changes neither halt, mon_rst_req nor fault_src.
- R6: With mon_en low, an accepted double fault raises halt from the next cycle. Halt then stays high until rst_n is asserted.
- R7: With mon_en high, an accepted double fault drives mon_rst_req high for exactly RST_PULSE_CYC cycles (default 1), starting the next cycle. Halt stays 0.
- R8: A bus_err is not accepted while halt is high or while mon_rst_req is high. An accepted fault closes the post-reset and exception windows.
- R9: A first_fetch without a simultaneous exc_start closes the post-reset and exception windows. An exc_start together with first_fetch leaves the exception window open.
- R10: fault_src bits are set for every window open at an accepted fault and are never cleared except by reset. Several bits may be set at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low external reset |
| mon_en | input | 1 | 1 selects reset-request response, 0 selects halt |
| bus_err | input | 1 | Bus error seen this cycle |
| exc_start | input | 1 | Strobe: bus-error exception processing begins |
| first_fetch | input | 1 | Strobe: first instruction (after reset or of a handler) fetched |
| rte_reload | input | 1 | Level: return-from-exception reloading a bus-error frame |
| halt | output | 1 | Sticky halt request |
| mon_rst_req | output | 1 | Monitor reset request pulse |
| fault_src | output | 3 | Sticky window record: bit0 post-reset, bit1 exception, bit2 frame reload |

## Verification
A window flag that fails to open or close shows one cycle after the offending bus error. It appears as a halt or reset pulse that should not be there, or one that is missing, and fault_src shows which window was wrong. A broken response path shows as halt dropping without a reset, a request pulse of the wrong length, or a second pulse while the first is still active. All of these are visible at the ports within one to two cycles of the stimulus. The bench sweeps each window against both response modes and several delays, then probes each window edge.

// File: rtl/dbf_pkg.sv
package dbf_pkg;
   localparam int unsigned DBF_NWIN = 3;
   localparam int unsigned WIN_RST  = 0;
   localparam int unsigned WIN_EXC  = 1;
   localparam int unsigned WIN_RTE  = 2;
   typedef logic [DBF_NWIN-1:0] dbf_win_t;
endpackage

// File: rtl/dbf_window_track.sv
module dbf_window_track
   import dbf_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     exc_start,
   input  logic     first_fetch,
   input  logic     rte_reload,
   input  logic     fault_acc,
   output dbf_win_t win
);
   logic win_rst_q;
   logic win_exc_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         win_rst_q <= 1'b1;
         win_exc_q <= 1'b0;
      end else begin
         win_rst_q <= win_rst_q & ~first_fetch & ~fault_acc;
         win_exc_q <= exc_start | (win_exc_q & ~first_fetch & ~fault_acc);
      end
   end

   always_comb begin
      win          = '0;
      win[WIN_RST] = win_rst_q;
      win[WIN_EXC] = win_exc_q;
      win[WIN_RTE] = rte_reload;
   end

   // R9: a fetch with no new exception leaves both fetch-closed windows shut
   p_fetch_closes_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (first_fetch && !exc_start) |=> (!win_rst_q && !win_exc_q));
   // R3: an exception start always opens the exception window
   p_exc_opens_r3: assert property (@(posedge clk) disable iff (!rst_n)
      exc_start |=> win_exc_q);
   // R2: the post-reset window can never reopen without a reset
   p_rst_win_once_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !win_rst_q |=> !win_rst_q);
endmodule

// File: rtl/dbf_response.sv
module dbf_response
   import dbf_pkg::*;
#(
   parameter int unsigned RST_PULSE_CYC = 1
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     mon_en,
   input  logic     bus_err,
   input  dbf_win_t win,
   output logic     fault_acc,
   output logic     halt,
   output logic     rst_req,
   output dbf_win_t fault_src
);
   localparam int unsigned CNT_W = $clog2(RST_PULSE_CYC + 1);

   generate
      if (RST_PULSE_CYC < 1 || RST_PULSE_CYC > 255) begin : g_bad_len
         $error("RST_PULSE_CYC must lie in 1..255");
      end
   endgenerate

   logic     halt_q;
   dbf_win_t src_q;

   assign fault_acc = bus_err & (|win) & ~halt_q & ~rst_req;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         halt_q <= 1'b0;
         src_q  <= '0;
      end else begin
         if (fault_acc && !mon_en) halt_q <= 1'b1;
         if (fault_acc)            src_q  <= src_q | win;
      end
   end

   generate
      if (RST_PULSE_CYC == 1) begin : g_single
         logic req_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) req_q <= 1'b0;
            else        req_q <= fault_acc & mon_en;
         end
         assign rst_req = req_q;
         // R7: a single-cycle request never lasts two cycles
         p_req_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
            rst_req |=> !rst_req);
      end else begin : g_counted
         logic [CNT_W-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                  cnt_q <= '0;
            else if (fault_acc && mon_en) cnt_q <= CNT_W'(RST_PULSE_CYC);
            else if (cnt_q != '0)         cnt_q <= cnt_q - 1'b1;
         end
         assign rst_req = (cnt_q != '0);
      end
   endgenerate

   assign halt      = halt_q;
   assign fault_src = src_q;

   // R6: halt holds until reset
   p_halt_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
      halt |=> halt);
   // R6: halt only rises after a bus error with the monitor disabled
   p_halt_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(halt) |-> $past(bus_err && !mon_en));
   // R7: enabled monitor answers with a request and no halt
   p_en_requests_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (fault_acc && mon_en) |=> (rst_req && !halt));
   // R8: halt and request never overlap
   p_no_overlap_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(halt && rst_req));
   // R10: recorded window bits never clear
   p_src_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ((fault_src & $past(fault_src)) == $past(fault_src)));
endmodule

// File: rtl/dbf_halt_monitor.sv
module dbf_halt_monitor
   import dbf_pkg::*;
#(
   parameter int unsigned RST_PULSE_CYC = 1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       mon_en,
   input  logic       bus_err,
   input  logic       exc_start,
   input  logic       first_fetch,
   input  logic       rte_reload,
   output logic       halt,
   output logic       mon_rst_req,
   output logic [2:0] fault_src
);
   dbf_win_t win;
   dbf_win_t src;
   logic     fault_acc;

   dbf_window_track u_track (
      .clk         (clk),
      .rst_n       (rst_n),
      .exc_start   (exc_start),
      .first_fetch (first_fetch),
      .rte_reload  (rte_reload),
      .fault_acc   (fault_acc),
      .win         (win)
   );

   dbf_response #(.RST_PULSE_CYC(RST_PULSE_CYC)) u_resp (
      .clk       (clk),
      .rst_n     (rst_n),
      .mon_en    (mon_en),
      .bus_err   (bus_err),
      .win       (win),
      .fault_acc (fault_acc),
      .halt      (halt),
      .rst_req   (mon_rst_req),
      .fault_src (src)
   );

   assign fault_src = src;

   // R5: with no window open a bus error is never accepted
   p_outside_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_err && win == '0) |=> ($stable(fault_src) && !$rose(halt)));
endmodule

// File: tb/tb_dbf_halt_monitor.sv
module tb_dbf_halt_monitor;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       mon_en = 1'b0;
   logic       bus_err = 1'b0;
   logic       exc_start = 1'b0;
   logic       first_fetch = 1'b0;
   logic       rte_reload = 1'b0;
   logic       halt;
   logic       mon_rst_req;
   logic [2:0] fault_src;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   dbf_halt_monitor dut (
      .clk(clk), .rst_n(rst_n), .mon_en(mon_en), .bus_err(bus_err),
      .exc_start(exc_start), .first_fetch(first_fetch), .rte_reload(rte_reload),
      .halt(halt), .mon_rst_req(mon_rst_req), .fault_src(fault_src)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0; bus_err = 0; exc_start = 0; first_fetch = 0; rte_reload = 0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic pulse_ff();
      first_fetch = 1; tick(); first_fetch = 0;
   endtask

   task automatic pulse_exc();
      exc_start = 1; tick(); exc_start = 0;
   endtask

   task automatic pulse_err();
      bus_err = 1; tick(); bus_err = 0;
   endtask

   task automatic run_case(input bit en, input int kind, input int d);
      logic [2:0] exp_src;
      string tag;
      exp_src = 3'b001 << kind;
      tag = (kind == 0) ? "R2" : (kind == 1) ? "R3" : "R4";
      do_reset();
      mon_en = en;
      if (kind != 0) pulse_ff();
      if (kind == 1) pulse_exc();
      if (kind == 2) rte_reload = 1;
      repeat (d) tick();
      pulse_err();
      rte_reload = 0;
      chk(tag, fault_src, exp_src);
      if (en) begin
         chk("R7 req", mon_rst_req, 1);
         chk("R7 nohalt", halt, 0);
      end else begin
         chk("R6 halt", halt, 1);
         chk("R6 noreq", mon_rst_req, 0);
      end
      tick();
      if (en) chk("R7 width", mon_rst_req, 0);
      else    chk("R6 hold", halt, 1);
      repeat (3) tick();
      chk(en ? "R7 nohalt late" : "R6 hold late", halt, en ? 0 : 1);
      chk("R10 src", fault_src, exp_src);
   endtask

   initial begin
      #(8 * 20000);
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      // R1 reset state
      repeat (2) @(negedge clk);
      chk("R1 halt in reset", halt, 0);
      chk("R1 req in reset", mon_rst_req, 0);
      chk("R1 src in reset", fault_src, 0);
      rst_n = 1'b1;
      tick();
      chk("R1 halt after release", halt, 0);
      chk("R1 src after release", fault_src, 0);

      // sweep: mode x window x delay
      for (int en = 0; en < 2; en++)
         for (int kind = 0; kind < 3; kind++)
            for (int d = 0; d < 3; d++)
               run_case(en[0], kind, d);

      // R5: no window open
      for (int en = 0; en < 2; en++) begin
         do_reset(); mon_en = en[0];
         pulse_ff();
         pulse_err();
         chk("R5 halt", halt, 0);
         chk("R5 req", mon_rst_req, 0);
         tick();
         chk("R5 src", fault_src, 0);
         chk("R5 halt late", halt, 0);
      end

      // R3: bus error in the same cycle as exc_start is not counted
      do_reset(); mon_en = 0;
      pulse_ff();
      exc_start = 1; bus_err = 1; tick(); exc_start = 0; bus_err = 0;
      chk("R3 same-cycle halt", halt, 0);
      chk("R3 same-cycle src", fault_src, 0);
      bus_err = 1; first_fetch = 1; tick(); bus_err = 0; first_fetch = 0;
      chk("R3 fetch-cycle counted", halt, 1);
      chk("R3 fetch-cycle src", fault_src, 3'b010);

      // R9: fetch closes exception window
      do_reset(); mon_en = 0;
      pulse_ff(); pulse_exc(); pulse_ff();
      pulse_err();
      chk("R9 closed halt", halt, 0);
      chk("R9 closed src", fault_src, 0);
      // R9: exc_start with first_fetch keeps window open
      exc_start = 1; first_fetch = 1; tick(); exc_start = 0; first_fetch = 0;
      pulse_err();
      chk("R9 reopen halt", halt, 1);
      chk("R9 reopen src", fault_src, 3'b010);

      // R4: RTE window closes when rte_reload drops
      do_reset(); mon_en = 0;
      pulse_ff();
      rte_reload = 1; tick(); rte_reload = 0;
      pulse_err();
      chk("R4 closed halt", halt, 0);
      chk("R4 closed src", fault_src, 0);

      // R8: halted ignores further faults
      do_reset(); mon_en = 0;
      pulse_ff(); pulse_exc(); pulse_err();
      chk("R8 halted", halt, 1);
      rte_reload = 1; mon_en = 1; pulse_err(); rte_reload = 0;
      chk("R8 halted src", fault_src, 3'b010);
      chk("R8 halted noreq", mon_rst_req, 0);

      // R8: faults during request pulse ignored; R2 window closed by fault
      do_reset(); mon_en = 1;
      pulse_err();
      chk("R8 first req", mon_rst_req, 1);
      pulse_err();
      chk("R8 busy ignored", mon_rst_req, 0);
      pulse_err();
      chk("R8 rst window closed", mon_rst_req, 0);
      rte_reload = 1;
      pulse_err();
      chk("R8 first rte req", mon_rst_req, 1);
      pulse_err();
      chk("R8 busy rte", mon_rst_req, 0);
      pulse_err();
      chk("R8 rte again", mon_rst_req, 1);
      rte_reload = 0;
      chk("R10 src accum", fault_src, 3'b101);

      // R10: several windows open at once
      do_reset(); mon_en = 0;
      rte_reload = 1;
      pulse_exc();
      pulse_err();
      rte_reload = 0;
      chk("R10 all bits", fault_src, 3'b111);
      chk("R6 multi halt", halt, 1);
      do_reset();
      tick();
      chk("R10 cleared by reset", fault_src, 0);
      chk("R6 cleared by reset", halt, 0);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule